// File: doc/BRIEF.md
# Phase-difference frequency discriminator

This block turns a stream of phase samples into instantaneous frequency. Each phase sample is an unsigned fraction of one full turn. The block first multiplies the sample by 1, 2, 4 or 8, modulo one turn. This folds BPSK, QPSK or 8PSK symbol jumps onto the carrier, so the modulation is stripped. It then subtracts the scaled phase that arrived D accepted samples earlier, where D runs from 1 to 8. The transfer function is H(z) = 1 − z^-D. Because the subtraction wraps at one full turn, a phase that crosses ±π produces no rollover error.

The 18-bit difference is rounded to a 16-bit signed frequency word and issued with a valid strobe, one cycle after the sample that produced it. A single packed configuration word selects the delay and the multiplier and switches the block on or off. The frequency stream normally feeds a separate post-filter.

Top module: `phase_freq_disc`

## Requirements
- R1: Bits 2:0 of `cfg_word` select the delay as D = field + 1, so 000 gives 1 and 111 gives 8. Each output is the scaled current phase minus the scaled phase accepted D samples earlier.
- R2: The subtraction is taken modulo 2^18, with the difference read as two's complement. Input 0x3FFF0 followed by 0x00010 at D=1 gives a difference of +32.
- R3: Bits 16:15 of `cfg_word` select the phase multiplier before differencing: 00 gives ×1, 01 gives ×2, 10 gives ×4 and 11 gives ×8. The multiplier is a left shift that drops the bits above bit 17.
- R4: `freq_data` equals floor((diff + 2) / 4), where diff is the signed 18-bit difference. A result above 32767 saturates to 32767, so diff 0x1FFFF gives 32767 and diff 0x20000 gives −32768.
- R5: Bit 14 of `cfg_word` is the enable. While it is 0, `freq_valid` is low the next cycle and `freq_data` holds its value. The sample history and the fill count are cleared.
- R6: After enable, the first D accepted samples produce no output, because the history does not yet hold D real samples.
- R7: Each sample taken with `ph_valid` high while enabled and primed produces exactly one `freq_valid` pulse, in the next cycle. `freq_valid` is never high without a sample in the cycle before, and `freq_data` changes only together with `freq_valid`.
- R8: During reset, `freq_valid` is 0 and `freq_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ph_valid | input | 1 | Phase sample strobe |
| ph_data | input | 18 | Phase, unsigned fraction of a turn |
| cfg_word | input | 17 | Delay select [2:0], enable [14], multiplier select [16:15] |
| freq_valid | output | 1 | Frequency word strobe |
| freq_data | output | 16 | Rounded signed frequency |

## Verification
Every result, whether a frequency word, a suppressed priming output or a disable, is due exactly one clock after the edge that takes the stimulus. The bench drives on the falling edge. At the next falling edge, after the single output register has updated, it compares `freq_valid` and `freq_data` with a bench model that steps once per cycle. `freq_data` is compared on every cycle, not only on strobes, so held values during disable and gaps are checked at the ports as well.

// File: rtl/pfd_pkg.sv
package pfd_pkg;
   localparam int CFG_W       = 17;
   localparam int CFG_DLY_LSB = 0;
   localparam int CFG_DLY_W   = 3;
   localparam int CFG_EN_BIT  = 14;
   localparam int CFG_MUL_LSB = 15;
   localparam int CFG_MUL_W   = 2;

   typedef struct packed {
      logic [CFG_MUL_W-1:0] mul_sel;
      logic                 enable;
      logic [CFG_DLY_W-1:0] dly_sel;
   } pfd_cfg_t;

   function automatic pfd_cfg_t unpack_cfg(input logic [CFG_W-1:0] w);
      pfd_cfg_t c;
      c.mul_sel = w[CFG_MUL_LSB +: CFG_MUL_W];
      c.enable  = w[CFG_EN_BIT];
      c.dly_sel = w[CFG_DLY_LSB +: CFG_DLY_W];
      return c;
   endfunction
endpackage

// File: rtl/pfd_phase_scale.sv
module pfd_phase_scale #(
   parameter int PH_W  = 18,
   parameter int SEL_W = 2
) (
   input  logic [PH_W-1:0]  ph_in,
   input  logic [SEL_W-1:0] shift_sel,
   output logic [PH_W-1:0]  ph_out
);
   localparam int N_OPT = 1 << SEL_W;

   logic [PH_W-1:0] opt [N_OPT];

   generate
      for (genvar k = 0; k < N_OPT; k++) begin : g_opt
         if (k == 0) begin : g_id
            assign opt[k] = ph_in;
         end else if (k < PH_W) begin : g_sh
            assign opt[k] = {ph_in[PH_W-1-k:0], {k{1'b0}}};
         end else begin : g_zero
            assign opt[k] = '0;
         end
      end
   endgenerate

   assign ph_out = opt[shift_sel];

   initial begin : chk_params
      assert (SEL_W >= 1 && SEL_W <= 4)
         else $error("pfd_phase_scale: SEL_W out of range");
   end
endmodule

// File: rtl/pfd_delay_line.sv
module pfd_delay_line #(
   parameter int W     = 18,
   parameter int DEPTH = 8
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     flush,
   input  logic                     push,
   input  logic [W-1:0]             din,
   input  logic [$clog2(DEPTH)-1:0] sel,
   output logic [W-1:0]             tap,
   output logic                     primed
);
   localparam int FILL_W = $clog2(DEPTH + 1);

   logic [W-1:0]      stage [DEPTH];
   logic [FILL_W-1:0] fill;

   generate
      for (genvar i = 0; i < DEPTH; i++) begin : g_stage
         always_ff @(posedge clk) begin
            if (!rst_n || flush) begin
               stage[i] <= '0;
            end else if (push) begin
               if (i == 0) stage[i] <= din;
               else        stage[i] <= stage[i-1];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n || flush)                          fill <= '0;
      else if (push && fill < FILL_W'(DEPTH))       fill <= fill + FILL_W'(1);
   end

   assign tap    = stage[sel];
   assign primed = fill > FILL_W'(sel);

   initial begin : chk_params
      assert (DEPTH >= 2) else $error("pfd_delay_line: DEPTH too small");
   end

   AST_FILL_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      fill <= FILL_W'(DEPTH)); // R6
   AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (fill == '0)); // R5
   AST_PUSH_COUNTS: assert property (@(posedge clk) disable iff (!rst_n)
      (push && !flush && fill < FILL_W'(DEPTH)) |=> (fill == $past(fill) + FILL_W'(1))); // R6
endmodule

// File: rtl/pfd_round.sv
module pfd_round #(
   parameter int IN_W  = 18,
   parameter int OUT_W = 16
) (
   input  logic signed [IN_W-1:0]  d_in,
   output logic signed [OUT_W-1:0] d_out
);
   localparam int DROP = IN_W - OUT_W;

   generate
      if (DROP == 0) begin : g_pass
         assign d_out = d_in;
      end else begin : g_rnd
         localparam logic signed [IN_W:0] HALF = (IN_W+1)'(1) <<< (DROP - 1);
         localparam logic signed [IN_W:0] MAXV = (IN_W+1)'((1 << (OUT_W-1)) - 1);
         logic signed [IN_W:0] ext, sum, shr;
         always_comb begin
            ext = {d_in[IN_W-1], d_in};
            sum = ext + HALF;
            shr = sum >>> DROP;
            if (shr > MAXV) d_out = MAXV[OUT_W-1:0];
            else            d_out = shr[OUT_W-1:0];
         end
      end
   endgenerate

   initial begin : chk_params
      assert (OUT_W <= IN_W && OUT_W >= 2) else $error("pfd_round: bad widths");
   end
endmodule

// File: rtl/phase_freq_disc.sv
module phase_freq_disc
   import pfd_pkg::*;
#(
   parameter int PH_W      = 18,
   parameter int FREQ_W    = 16,
   parameter int MAX_DELAY = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ph_valid,
   input  logic [PH_W-1:0]   ph_data,
   input  logic [CFG_W-1:0]  cfg_word,
   output logic              freq_valid,
   output logic [FREQ_W-1:0] freq_data
);
   localparam int SEL_W = $clog2(MAX_DELAY);

   pfd_cfg_t             cfg;
   logic [PH_W-1:0]      scaled, tap;
   logic signed [PH_W-1:0] diff;
   logic signed [FREQ_W-1:0] rounded;
   logic                 take, primed;

   assign cfg  = unpack_cfg(cfg_word);
   assign take = ph_valid && cfg.enable;

   pfd_phase_scale #(.PH_W(PH_W), .SEL_W(CFG_MUL_W)) u_scale (
      .ph_in(ph_data), .shift_sel(cfg.mul_sel), .ph_out(scaled));

   pfd_delay_line #(.W(PH_W), .DEPTH(MAX_DELAY)) u_line (
      .clk(clk), .rst_n(rst_n), .flush(!cfg.enable), .push(take),
      .din(scaled), .sel(cfg.dly_sel[SEL_W-1:0]), .tap(tap), .primed(primed));

   assign diff = scaled - tap;

   pfd_round #(.IN_W(PH_W), .OUT_W(FREQ_W)) u_round (
      .d_in(diff), .d_out(rounded));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         freq_valid <= 1'b0;
         freq_data  <= '0;
      end else begin
         freq_valid <= take && primed;
         if (take && primed) freq_data <= rounded;
      end
   end

   initial begin : chk_params
      assert (MAX_DELAY == (1 << CFG_DLY_W))
         else $error("phase_freq_disc: MAX_DELAY must match delay field");
   end

   AST_OFF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg.enable |=> !freq_valid); // R5
   AST_OUT_NEEDS_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
      freq_valid |-> $past(ph_valid)); // R7
   AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !freq_valid |-> $stable(freq_data)); // R7
   AST_UNPRIMED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (take && !primed) |=> !freq_valid); // R6
endmodule

// File: tb/sim_phase_freq_disc.sv
module sim_phase_freq_disc;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        ph_valid;
   logic [17:0] ph_data;
   logic [16:0] cfg_word;
   logic        freq_valid;
   logic [15:0] freq_data;

   int total = 0;
   int bad   = 0;
   string tag = "R8";

   logic [17:0] hist [8];
   int          cnt;
   logic        exp_valid;
   logic [15:0] exp_data;
   bit          have_exp;

   always #5 clk = ~clk;

   phase_freq_disc u0 (
      .clk(clk), .rst_n(rst_n), .ph_valid(ph_valid), .ph_data(ph_data),
      .cfg_word(cfg_word), .freq_valid(freq_valid), .freq_data(freq_data));

   function automatic logic [16:0] mk_cfg(input bit en, input int mul, input int dly);
      logic [16:0] c = '0;
      c[16:15] = mul[1:0];
      c[14]    = en;
      c[2:0]   = dly[2:0];
      return c;
   endfunction

   function automatic logic [15:0] rnd(input logic [17:0] d);
      int v = $signed(d);
      int q = (v + 2) >>> 2;
      if (q > 32767) q = 32767;
      return q[15:0];
   endfunction

   task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   task automatic step(input bit v, input logic [17:0] ph, input logic [16:0] cfg);
      @(negedge clk);
      if (have_exp) begin
         check("freq_valid", {31'b0, freq_valid}, {31'b0, exp_valid});
         check("freq_data", {16'b0, freq_data}, {16'b0, exp_data});
      end
      ph_valid = v; ph_data = ph; cfg_word = cfg;
      have_exp = 1'b1;
      if (!cfg[14]) begin
         for (int i = 0; i < 8; i++) hist[i] = '0;
         cnt = 0;
         exp_valid = 1'b0;
      end else if (v) begin
         logic [17:0] s = ph << cfg[16:15];
         int d = int'(cfg[2:0]) + 1;
         exp_valid = (cnt >= d);
         if (exp_valid) exp_data = rnd(s - hist[d-1]);
         for (int i = 7; i > 0; i--) hist[i] = hist[i-1];
         hist[0] = s;
         if (cnt < 8) cnt++;
      end else begin
         exp_valid = 1'b0;
      end
   endtask

   initial begin
      #(200000 * 10);
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      void'($urandom(32'h5EED_1234));
      rst_n = 1'b0; ph_valid = 1'b0; ph_data = '0; cfg_word = '0;
      have_exp = 1'b0; cnt = 0; exp_valid = 1'b0; exp_data = '0;
      for (int i = 0; i < 8; i++) hist[i] = '0;
      repeat (3) @(negedge clk);
      tag = "R8";
      check("reset valid", {31'b0, freq_valid}, 32'd0);
      check("reset data", {16'b0, freq_data}, 32'd0);
      rst_n = 1'b1;

      // R1 / R6: ramp through every delay, re-priming each time
      tag = "R1";
      for (int d = 0; d < 8; d++) begin
         step(1'b0, '0, mk_cfg(0, 0, d));
         for (int n = 0; n < 12; n++) step(1'b1, 18'(n * n * 37 + d * 1000), mk_cfg(1, 0, d));
      end

      // R2: wrap across the full-turn boundary
      tag = "R2";
      step(1'b0, '0, mk_cfg(0, 0, 0));
      step(1'b1, 18'h3FFF0, mk_cfg(1, 0, 0));
      step(1'b1, 18'h00010, mk_cfg(1, 0, 0));
      step(1'b1, 18'h3FFE0, mk_cfg(1, 0, 0));

      // R3: each multiplier
      tag = "R3";
      for (int m = 0; m < 4; m++) begin
         step(1'b0, '0, mk_cfg(0, m, 1));
         for (int n = 0; n < 6; n++) step(1'b1, 18'h08000 + 18'(n * 5171), mk_cfg(1, m, 1));
      end

      // R4: rounding and saturation extremes
      tag = "R4";
      step(1'b0, '0, mk_cfg(0, 0, 0));
      step(1'b1, 18'h00000, mk_cfg(1, 0, 0));
      step(1'b1, 18'h1FFFF, mk_cfg(1, 0, 0));
      step(1'b1, 18'h3FFFF, mk_cfg(1, 0, 0));
      step(1'b1, 18'h00000, mk_cfg(1, 0, 0));
      step(1'b1, 18'h00001, mk_cfg(1, 0, 0));
      step(1'b1, 18'h3FFFE, mk_cfg(1, 0, 0));
      step(1'b1, 18'h00001, mk_cfg(1, 0, 0));

      // R5 / R7: disable mid-stream, gaps between samples
      tag = "R5";
      for (int n = 0; n < 5; n++) step(1'b1, 18'(n * 9001), mk_cfg(1, 0, 2));
      step(1'b1, 18'h12345, mk_cfg(0, 0, 2));
      step(1'b1, 18'h23456, mk_cfg(0, 0, 2));
      tag = "R6";
      for (int n = 0; n < 5; n++) step(1'b1, 18'(n * 777), mk_cfg(1, 0, 2));
      tag = "R7";
      for (int n = 0; n < 10; n++) step(n[0], 18'(n * 4321), mk_cfg(1, 1, 0));

      // random mix
      tag = "R7";
      begin
         int mul = 0, dly = 0;
         bit en = 1'b1;
         for (int n = 0; n < 3000; n++) begin
            if ($urandom_range(0, 99) < 3) mul = $urandom_range(0, 3);
            if ($urandom_range(0, 99) < 3) dly = $urandom_range(0, 7);
            if ($urandom_range(0, 199) < 2) en = ~en;
            step($urandom_range(0, 3) != 0, 18'($urandom), mk_cfg(en, mul, dly));
         end
      end
      step(1'b0, '0, mk_cfg(1, 0, 0));
      step(1'b0, '0, mk_cfg(1, 0, 0));

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule